// File: doc/BRIEF.md
# Posted Write Flow-Control Timer

This block decides, cycle by cycle, whether a bus target that posts every write can take the data beat on offer. Writes go into a pair of small internal buffers and are never held back for the slower internal memory access. The only reason to hold a beat back is that the buffers report full. While they are full, the block keeps target-ready low, which inserts data wait states on the bus.

Each stalled beat is timed. The first beat of a transaction may wait 16 clocks. Every later beat may wait 8 clocks. When a beat goes past its allowance and the disconnect enable is set, the block raises a one-cycle stop request and accepts nothing more from that transaction. When the enable is clear, the stall simply goes on until space frees up.

A write transaction is framed by a start marker and an end marker, each one cycle long. A data phase counts only in a cycle that carries neither marker.

Top module: `pwt_flow_ctrl`

## Requirements
- R1: After reset, and while no transaction is open, `trdy` and `stop_req` are both 0.
- R2: In an open transaction, `trdy` is 1 in the same cycle as a data phase (`beat_valid`=1, no start or end marker) whenever `buf_full` is 0.
- R3: While `buf_full` is 1, `trdy` is 0.
- R4: When `disc_en` is 1, the first beat of a transaction may stall for 16 data-phase cycles with no stop. If it is still stalled on the 17th such cycle, `stop_req` is 1 in that cycle.
- R5: When `disc_en` is 1, each later beat may stall for 8 data-phase cycles. If it is still stalled on the 9th such cycle, `stop_req` is 1 in that cycle.
- R6: When `disc_en` is 0, `stop_req` stays 0 however long the stall lasts, and `trdy` returns once `buf_full` falls.
- R7: When space frees up before the limit, the beat completes with no stop. The next beat's stall is timed from zero.
- R8: `stop_req` lasts one cycle, with `trdy` at 0 in that cycle. Afterwards `trdy` stays 0 until the next start marker, whatever `buf_full` does.
- R9: A start marker clears the stall count, and the next beat has the 16-cycle first-beat allowance again. This holds even if the start marker arrives in the middle of a stalled transaction.
- R10: A cycle with `beat_valid`=0 neither completes a beat nor advances the stall count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | One-cycle marker that opens a write transaction |
| txn_end | input | 1 | One-cycle marker that closes the transaction |
| beat_valid | input | 1 | Initiator presents a data beat |
| buf_full | input | 1 | Posted write buffers have no room |
| disc_en | input | 1 | Allow a disconnect when a stall runs past its limit |
| trdy | output | 1 | Target ready: the beat is accepted this cycle |
| stop_req | output | 1 | One-cycle target disconnect request |

## Verification
The bench drives stalls that end exactly at the limit and one cycle past it, for both the first beat and later beats. A design with an off-by-one count would stop one cycle early or late, and one that used a single limit would get one of the two beat kinds wrong. The bench also frees the buffers just in time and then stalls the next beat fully, so a counter that is not cleared on a completed beat would stop too soon. It restarts a transaction in the middle of a stall, which catches a design that keeps the later-beat limit or a stale count. It inserts idle data-phase cycles inside a stall, which a design that counts every clock would turn into an early stop. After a disconnect it lowers `buf_full`, where a leaky design would raise `trdy` again. Long random runs with the enable both set and clear are compared against a bench model each cycle.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_CUT  = 2'd2
  } pwt_state_t;

  // Wait allowance for the beat now on offer.
  function automatic int beat_limit(input bit first, input int first_lim,
                                    input int next_lim);
    return first ? first_lim : next_lim;
  endfunction

endpackage

// File: rtl/pwt_txn_fsm.sv
module pwt_txn_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               end_i,
  input  logic               beat_done_i,
  input  logic               cut_i,
  output pwt_pkg::pwt_state_t state_o,
  output logic               first_o
);
  import pwt_pkg::*;

  pwt_state_t state_q, state_d;
  logic       first_q;

  always_comb begin
    state_d = state_q;
    if (start_i)                      state_d = ST_OPEN;
    else if (end_i)                   state_d = ST_IDLE;
    else if (cut_i && state_q == ST_OPEN) state_d = ST_CUT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (start_i)          first_q <= 1'b1;
      else if (beat_done_i) first_q <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign first_o = first_q;
endmodule

// File: rtl/pwt_stall_timer.sv
module pwt_stall_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             stall_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (stall_i && !expired_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwt_flow_ctrl.sv
module pwt_flow_ctrl #(
  parameter int FIRST_LIMIT = 16,
  parameter int NEXT_LIMIT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txn_start,
  input  logic txn_end,
  input  logic beat_valid,
  input  logic buf_full,
  input  logic disc_en,
  output logic trdy,
  output logic stop_req
);
  import pwt_pkg::*;

  localparam int MAX_LIMIT = (FIRST_LIMIT > NEXT_LIMIT) ? FIRST_LIMIT : NEXT_LIMIT;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  pwt_state_t       state;
  logic             first_beat;
  logic             in_open;
  logic             in_disc;
  logic             data_phase;
  logic             beat_done;
  logic             stalled;
  logic             expired;
  logic             cut;
  logic [CNT_W-1:0] cur_limit;
  logic [CNT_W-1:0] stall_cnt;

  assign in_open    = (state == ST_OPEN);
  assign in_disc    = (state == ST_CUT);
  assign data_phase = in_open && beat_valid && !txn_start && !txn_end;
  assign beat_done  = data_phase && !buf_full;
  assign stalled    = data_phase && buf_full;
  assign cur_limit  = CNT_W'(beat_limit(first_beat, FIRST_LIMIT, NEXT_LIMIT));
  assign cut        = stalled && expired && disc_en;

  pwt_txn_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (txn_start),
    .end_i       (txn_end),
    .beat_done_i (beat_done),
    .cut_i       (cut),
    .state_o     (state),
    .first_o     (first_beat)
  );

  pwt_stall_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (txn_start || beat_done),
    .stall_i   (stalled),
    .limit_i   (cur_limit),
    .cnt_o     (stall_cnt),
    .expired_o (expired)
  );

  assign trdy     = beat_done;
  assign stop_req = cut;
endmodule

// File: rtl/pwt_flow_ctrl_chk.sv
module pwt_flow_ctrl_chk #(
  parameter int FIRST_LIMIT = 16,
  parameter int CNT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_start,
  input logic             buf_full,
  input logic             disc_en,
  input logic             trdy,
  input logic             stop_req,
  input logic             in_disc,
  input logic             first_beat,
  input logic [CNT_W-1:0] stall_cnt
);
  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !trdy);

  assert_stop_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  assert_stop_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !trdy);

  assert_cut_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_disc |-> !trdy);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= CNT_W'(FIRST_LIMIT));

  assert_beat_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trdy |=> (stall_cnt == '0) && !first_beat);

  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> (stall_cnt == '0) && first_beat);

  assert_off_no_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !disc_en |-> !stop_req);
endmodule

bind pwt_flow_ctrl pwt_flow_ctrl_chk #(.FIRST_LIMIT(FIRST_LIMIT), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .txn_start  (txn_start),
  .buf_full   (buf_full),
  .disc_en    (disc_en),
  .trdy       (trdy),
  .stop_req   (stop_req),
  .in_disc    (in_disc),
  .first_beat (first_beat),
  .stall_cnt  (stall_cnt)
);

// File: tb/pwt_flow_ctrl_tb.sv
module pwt_flow_ctrl_tb_top;
  localparam int FL = 16;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_start = 1'b0, txn_end = 1'b0, beat_valid = 1'b0;
  logic buf_full = 1'b0, disc_en = 1'b0;
  logic trdy, stop_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // bench model: 0 idle, 1 open, 2 cut
  int  m_state = 0;
  bit  m_first = 1'b1;
  int  m_cnt = 0;

  always #2 clk = ~clk;

  pwt_flow_ctrl #(.FIRST_LIMIT(FL), .NEXT_LIMIT(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
    .beat_valid(beat_valid), .buf_full(buf_full), .disc_en(disc_en),
    .trdy(trdy), .stop_req(stop_req)
  );

  function automatic int allowance(bit first);
    if (first) return FL;
    return NL;
  endfunction

  function automatic bit in_phase(bit bv, bit st, bit en);
    return (m_state == 1) && bv && !st && !en;
  endfunction

  task automatic step(input bit bv, input bit bf, input bit st, input bit en,
                      input bit de, input string tag);
    bit ph, exp_r, exp_s;
    @(negedge clk);
    beat_valid = bv; buf_full = bf; txn_start = st; txn_end = en; disc_en = de;
    #1;
    ph    = in_phase(bv, st, en);
    exp_r = ph && !bf;
    exp_s = ph && bf && de && (m_cnt >= allowance(m_first));
    checks++;
    if (trdy !== exp_r || stop_req !== exp_s) begin
      failures++;
      $display("FAIL %s: trdy=%b stop_req=%b expected trdy=%b stop_req=%b",
               tag, trdy, stop_req, exp_r, exp_s);
    end
    @(posedge clk);
    if (st) begin m_state = 1; m_first = 1'b1; m_cnt = 0; end
    else if (en) m_state = 0;
    else if (exp_s) m_state = 2;
    else if (exp_r) begin m_cnt = 0; m_first = 1'b0; end
    else if (ph && bf && m_cnt < allowance(m_first)) m_cnt++;
  endtask

  task automatic open_txn(input bit de, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, de, tag);
  endtask

  task automatic close_txn(input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset and idle state
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1");

    // R2 posted beats accepted at once; R4 first-beat limit
    open_txn(1'b1, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    close_txn("R2");
    open_txn(1'b1, "R4");
    for (int i = 0; i < FL; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
    // R8 no more beats after the cut, even with room
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    close_txn("R8");

    // R5 later-beat limit
    open_txn(1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
    for (int i = 0; i < NL; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    close_txn("R5");

    // R6 disconnect disabled: stall continues, then resumes
    open_txn(1'b0, "R6");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    close_txn("R6");

    // R7 free just in time, next beat timed from zero
    open_txn(1'b1, "R7");
    for (int i = 0; i < FL; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    for (int i = 0; i < NL; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    close_txn("R7");

    // R9 restart mid-stall restores first-beat allowance
    open_txn(1'b1, "R9");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    open_txn(1'b1, "R9");
    for (int i = 0; i < FL; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    close_txn("R9");

    // R10 idle data phases inside a stall are not counted
    open_txn(1'b1, "R10");
    for (int i = 0; i < FL; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
    end
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    close_txn("R10");

    // random traffic against the model (R2 R3 R4 R5 R6)
    for (int i = 0; i < 4000; i++) begin
      bit st, en, bv, bf, de;
      st = ($urandom % 60) == 0;
      en = !st && (($urandom % 80) == 0);
      bv = ($urandom % 4) != 0;
      bf = ($urandom % 8) < 6;
      de = (i / 1000) % 2 == 0;
      step(bv, bf, st, en, de, "R2");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule